// File: doc/BRIEF.md
# Flag-Buffered Byte ALU

This block is the arithmetic logic unit of a small 8-bit processor. One operand comes from the main read-write data bus and the other from the auxiliary write-only bus. A 4-bit opcode selects one of nine operations: add, subtract, bitwise AND, OR, XOR, invert, shift left, shift right and compare. The block does not write its result to any destination directly. The result goes into a temporary result register, and a later micro-step of the control unit moves it onto the bus.

The same enabled cycle also loads a carry flag and a zero flag. The conditional jump and loop logic reads these flags. The carry flag uses inverted polarity: a stored 0 means a carry or borrow occurred, and a stored 1 means none did. Compare sets both flags the same way subtract does, but leaves the result register untouched. The result register and the flags load only on a rising clock edge where the enable input is high. The new values appear on the outputs right after that edge.

Top module: `flagged_alu`

## Requirements
- R1: With alu_en high and op = 0 (add), the next edge loads t_q with (bus_a + bus_b) mod 256. It loads c_q with 0 when the true sum exceeds 255, and with 1 otherwise.
- R2: With alu_en high and op = 1 (subtract), the next edge loads t_q with (bus_a − bus_b) mod 256. It loads c_q with 0 when bus_a < bus_b (borrow), and with 1 otherwise.
- R3: With alu_en high, op = 2 (AND), 3 (OR) and 4 (XOR) load t_q with the bitwise combination of the two operands. Op = 5 (invert) loads ~bus_a and ignores bus_b. All four of these operations load c_q with 1.
- R4: Op = 6 (shift left) and op = 7 (shift right) shift bus_a by one place and fill the vacated bit with 0. The bit shifted out is stored inverted in c_q: shifting out a 1 gives c_q = 0.
- R5: Op = 8 (compare) loads c_q exactly as subtract does and leaves t_q unchanged.
- R6: For ops 0 to 8, z_q is loaded with 1 when the 8-bit result is zero, and with 0 otherwise. For compare, the result is the difference bus_a − bus_b.
- R7: While alu_en is low, t_q, c_q and z_q keep their values whatever op and the operands do.
- R8: Opcodes 9 to 15 leave t_q, c_q and z_q unchanged even with alu_en high.
- R9: While rst_n is low, t_q is 0, z_q is 0 and c_q is 1 (no carry).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_en | input | 1 | Load strobe for the result register and flags |
| op | input | 4 | Operation select |
| bus_a | input | 8 | First operand, from the main data bus |
| bus_b | input | 8 | Second operand, from the auxiliary bus |
| t_q | output | 8 | Temporary result register |
| c_q | output | 1 | Carry flag, stored inverted (0 = carry/borrow) |
| z_q | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and the active-low carry variant. At this width, the overflow at 255, the borrow below zero, and the bits shifted out of positions 7 and 0 are all reached by hand-picked operand pairs. A pseudo-random run then covers all sixteen opcodes with the enable toggling. This exercises the seven unused codes, the held state when the enable is low, and compare's untouched result register.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_NOT = 4'd5,
      OP_SHL = 4'd6,
      OP_SHR = 4'd7,
      OP_CMP = 4'd8
   } alu_op_e;

   typedef struct packed {
      logic load_result;
      logic load_flags;
   } alu_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import flagged_alu_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic            enable,
   input  logic [OP_W-1:0] opcode,
   output alu_ctl_t        ctl
);

   always_comb begin
      ctl = '0;
      if (enable) begin
         case (opcode)
            OP_ADD, OP_SUB, OP_AND, OP_OR,
            OP_XOR, OP_NOT, OP_SHL, OP_SHR: begin
               ctl.load_result = 1'b1;
               ctl.load_flags  = 1'b1;
            end
            OP_CMP:  ctl.load_flags = 1'b1;
            default: ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
   import flagged_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int OP_W  = 4
) (
   input  logic [OP_W-1:0]  opcode,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] sum_ext;
   logic [EXT_W-1:0] diff_ext;

   assign sum_ext  = {1'b0, opa} + {1'b0, opb};
   assign diff_ext = {1'b0, opa} - {1'b0, opb};

   always_comb begin
      result    = '0;
      carry_out = 1'b0;
      case (opcode)
         OP_ADD: begin
            result    = sum_ext[WIDTH-1:0];
            carry_out = sum_ext[WIDTH];
         end
         OP_SUB, OP_CMP: begin
            result    = diff_ext[WIDTH-1:0];
            carry_out = diff_ext[WIDTH];
         end
         OP_AND: result = opa & opb;
         OP_OR:  result = opa | opb;
         OP_XOR: result = opa ^ opb;
         OP_NOT: result = ~opa;
         OP_SHL: begin
            result    = {opa[WIDTH-2:0], 1'b0};
            carry_out = opa[WIDTH-1];
         end
         OP_SHR: begin
            result    = {1'b0, opa[WIDTH-1:1]};
            carry_out = opa[0];
         end
         default: begin
            result    = '0;
            carry_out = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_result_regs.sv
module alu_result_regs
   import flagged_alu_pkg::*;
#(
   parameter int WIDTH            = 8,
   parameter bit CARRY_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  alu_ctl_t         ctl,
   input  logic [WIDTH-1:0] result,
   input  logic             carry_raw,
   output logic [WIDTH-1:0] t_q,
   output logic             c_q,
   output logic             z_q
);

   localparam logic C_IDLE = CARRY_ACTIVE_LOW ? 1'b1 : 1'b0;

   logic c_next;
   logic z_next;

   generate
      if (CARRY_ACTIVE_LOW) begin : g_carry_inv
         assign c_next = ~carry_raw;
      end else begin : g_carry_true
         assign c_next = carry_raw;
      end
   endgenerate

   assign z_next = (result == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (ctl.load_result) begin
         t_q <= result;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= C_IDLE;
         z_q <= 1'b0;
      end else if (ctl.load_flags) begin
         c_q <= c_next;
         z_q <= z_next;
      end
   end

   // R7/R8: with no load requested, the state holds
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.load_flags |=> ($stable(t_q) && $stable(c_q) && $stable(z_q)))
      else $error("state changed without a load");

   // R5: a flag-only load keeps the result register
   p_flag_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.load_flags && !ctl.load_result) |=> $stable(t_q))
      else $error("result register moved on a flag-only load");

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
   import flagged_alu_pkg::*;
#(
   parameter int WIDTH            = 8,
   parameter int OP_W             = 4,
   parameter bit CARRY_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alu_en,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] bus_a,
   input  logic [WIDTH-1:0] bus_b,
   output logic [WIDTH-1:0] t_q,
   output logic             c_q,
   output logic             z_q
);

   localparam logic C_NONE = CARRY_ACTIVE_LOW ? 1'b1 : 1'b0;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flagged_alu: WIDTH must be at least 2");
      end
      if (OP_W != 4) begin : g_bad_opw
         $error("flagged_alu: OP_W must be 4");
      end
   endgenerate

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] dp_result;
   logic             dp_carry;

   alu_op_decode #(.OP_W(OP_W)) u_decode (
      .enable (alu_en),
      .opcode (op),
      .ctl    (ctl)
   );

   alu_datapath #(.WIDTH(WIDTH), .OP_W(OP_W)) u_datapath (
      .opcode    (op),
      .opa       (bus_a),
      .opb       (bus_b),
      .result    (dp_result),
      .carry_out (dp_carry)
   );

   alu_result_regs #(.WIDTH(WIDTH), .CARRY_ACTIVE_LOW(CARRY_ACTIVE_LOW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .result    (dp_result),
      .carry_raw (dp_carry),
      .t_q       (t_q),
      .c_q       (c_q),
      .z_q       (z_q)
   );

   // R6: zero flag tracks the stored result for result-writing ops
   p_zero_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && op <= 4'd7) |=> (z_q == (t_q == '0)))
      else $error("zero flag disagrees with result");

   // R3: logic operations report no carry
   p_logic_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && op >= 4'd2 && op <= 4'd5) |=> (c_q == C_NONE))
      else $error("logic op left a carry");

   // R4: shift-left fills bit 0 with zero
   p_shl_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && op == 4'd6) |=> (t_q[0] == 1'b0))
      else $error("shift left fill not zero");

   // R4: shift-right fills the top bit with zero
   p_shr_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && op == 4'd7) |=> (t_q[WIDTH-1] == 1'b0))
      else $error("shift right fill not zero");

   // R8: undefined opcodes change nothing
   p_undef_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_en && op >= 4'd9) |=> ($stable(t_q) && $stable(c_q) && $stable(z_q)))
      else $error("undefined opcode changed state");

endmodule

// File: tb/flagged_alu_test.sv
module flagged_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alu_en = 1'b0;
   logic [3:0] op = 4'd0;
   logic [7:0] bus_a = 8'd0;
   logic [7:0] bus_b = 8'd0;
   logic [7:0] t_q;
   logic       c_q;
   logic       z_q;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [7:0] m_t = 8'h00;
   logic       m_c = 1'b1;
   logic       m_z = 1'b0;

   logic [9:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   flagged_alu uut (
      .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .op(op),
      .bus_a(bus_a), .bus_b(bus_b), .t_q(t_q), .c_q(c_q), .z_q(z_q)
   );

   task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got t=%h c=%b z=%b, expected t=%h c=%b z=%b",
                  tag, got[9:2], got[1], got[0], exp[9:2], exp[1], exp[0]);
      end
   endtask

   // bench model of the required behaviour
   task automatic model(input logic en, input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
      int s;
      if (!en || o > 4'd8) return;
      case (o)
         4'd0: begin s = int'(a) + int'(b); m_t = s[7:0]; m_c = (s > 255) ? 1'b0 : 1'b1; end
         4'd1, 4'd8: begin
            s = int'(a) - int'(b);
            if (o == 4'd1) m_t = s[7:0];
            m_c = (a < b) ? 1'b0 : 1'b1;
            m_z = (a == b);
         end
         4'd2: begin m_t = a & b; m_c = 1'b1; end
         4'd3: begin m_t = a | b; m_c = 1'b1; end
         4'd4: begin m_t = a ^ b; m_c = 1'b1; end
         4'd5: begin m_t = ~a;    m_c = 1'b1; end
         4'd6: begin m_t = {a[6:0], 1'b0}; m_c = ~a[7]; end
         default: begin m_t = {1'b0, a[7:1]}; m_c = ~a[0]; end
      endcase
      if (o <= 4'd7) m_z = (m_t == 8'h00);
   endtask

   task automatic apply(input string tag, input logic en, input logic [3:0] o,
                        input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      alu_en = en; op = o; bus_a = a; bus_b = b;
      model(en, o, a, b);
      exp_q.push_back({m_t, m_c, m_z});
      tag_q.push_back(tag);
   endtask

   // monitor: compare one expected item after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [9:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, {t_q, c_q, z_q}, e);
         end
      end
   end

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      check("R9 reset", {t_q, c_q, z_q}, {8'h00, 1'b1, 1'b0});
      rst_n = 1'b1;

      apply("R1 add", 1, 4'd0, 8'h10, 8'h20);
      apply("R1 add overflow", 1, 4'd0, 8'hFF, 8'h01);
      apply("R1 add 255", 1, 4'd0, 8'hFE, 8'h01);
      apply("R2 sub", 1, 4'd1, 8'h05, 8'h03);
      apply("R2 sub borrow", 1, 4'd1, 8'h03, 8'h05);
      apply("R6 sub zero", 1, 4'd1, 8'h77, 8'h77);
      apply("R3 and", 1, 4'd2, 8'hF0, 8'h3C);
      apply("R3 or", 1, 4'd3, 8'hF0, 8'h0C);
      apply("R3 xor", 1, 4'd4, 8'hAA, 8'hAA);
      apply("R3 not ignores b", 1, 4'd5, 8'h0F, 8'h55);
      apply("R4 shl out one", 1, 4'd6, 8'h81, 8'h00);
      apply("R4 shr to zero", 1, 4'd7, 8'h01, 8'hFF);
      apply("R4 shr out zero", 1, 4'd7, 8'h80, 8'h00);
      apply("R5 cmp less", 1, 4'd8, 8'h05, 8'h09);
      apply("R5 cmp equal", 1, 4'd8, 8'h09, 8'h09);
      apply("R7 disabled add", 0, 4'd0, 8'h12, 8'h34);
      apply("R8 undefined op", 1, 4'd12, 8'h00, 8'h00);
      apply("R8 undefined op 9", 1, 4'd9, 8'hFF, 8'hFF);

      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         apply("R1 R2 R3 R4 R5 R6 R7 R8 random", lfsr[0] | lfsr[5], lfsr[11:8],
               lfsr[7:0] ^ 8'(i), lfsr[15:8]);
      end

      @(negedge clk);
      alu_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            vectors++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
         end
      join_any
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule